// File: doc/BRIEF.md
# Standby Mode Sequencer

This block puts a small processor into one of two low-power standby states and brings it back out. A light standby (halt) gates only the CPU clock and leaves every oscillator running, so the core can restart on the very next cycle. A deep standby (stop) also shuts down the high-speed crystal oscillator and the internal high-speed oscillator. The subsystem oscillator is never touched.

Deep standby is refused while the CPU runs from the subsystem clock. Either state ends when an interrupt is pending. Waking from deep standby with the crystal as main clock keeps the CPU clock gated until a programmable number of oscillator ticks has passed. A thermometer status word shows how far that wait has progressed. Every exit from standby ends with a one-cycle resume strobe.

The wait length sits in a 3-bit select register that the CPU writes while running. The exponent base is the parameter `EXP_BASE` (default 11). Thresholds are powers of two above that base.

Top module: `sby_ctrl`

## Requirements
- R1: In the active state, a `halt_req` pulse with `stop_req` low and no pending interrupt drops `cpu_clk_en` on the next cycle. `xtal_osc_en` and `hs_int_osc_en` stay 1.
- R2: In the active state, a `stop_req` pulse with `clk_on_sub`=0 and no pending interrupt drops `cpu_clk_en`, `xtal_osc_en` and `hs_int_osc_en` to 0 on the next cycle. On that same cycle `stab_status` reads 0.
- R3: A `stop_req` while `clk_on_sub`=1 is ignored: `cpu_clk_en` stays 1 and no strobe is issued. A `halt_req` while `clk_on_sub`=1 is accepted as in R1.
- R4: If `irq_pend` is 1 in the cycle a halt or stop request arrives, the request is dropped and `cpu_clk_en` stays 1.
- R5: In light standby, `irq_pend`=1 makes `cpu_clk_en` and `resume_pulse` both 1 on the next cycle. `resume_pulse` is high for exactly one cycle.
- R6: In deep standby with `main_is_xtal`=0, `irq_pend`=1 makes `cpu_clk_en`, `resume_pulse` and both oscillator enables 1 on the next cycle.
- R7: In deep standby with `main_is_xtal`=1, `irq_pend`=1 turns both oscillator enables on the next cycle, and the CPU clock stays gated. Only cycles with `osc_tick`=1 are counted. `cpu_clk_en` and `resume_pulse` rise on the cycle after the T-th counted tick.
- R8: Select code to T, where B = `EXP_BASE`: 0 gives 2^B; 1 gives 2^(B+2); 2 gives 2^(B+3); 3 gives 2^(B+4); 4 gives 2^(B+5); 5 and 6 give 2^(B+6); 7 gives 2^(B+7). `stab_sel` resets to 7.
- R9: `stab_status` bit i (i = 0..6) is 1 once the tick count reaches 2^(B+k_i), with k = 0,2,3,4,5,6,7. It holds its value after resume until the next deep-standby entry. It resets to 0.
- R10: `sel_we`=1 in the active state loads `sel_wdata` into `stab_sel`, visible on the next cycle. Writes made during either standby state are ignored.
- R11: If `halt_req` and `stop_req` arrive together, stop wins when `clk_on_sub`=0, and halt is taken when `clk_on_sub`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Light-standby request pulse |
| stop_req | input | 1 | Deep-standby request pulse |
| clk_on_sub | input | 1 | 1 = CPU runs from subsystem clock |
| main_is_xtal | input | 1 | 1 = main clock is the crystal oscillator |
| irq_pend | input | 1 | An interrupt request is pending |
| osc_tick | input | 1 | One oscillator tick for the stabilization count |
| sel_we | input | 1 | Write strobe for the wait-length select |
| sel_wdata | input | 3 | Wait-length select write data |
| cpu_clk_en | output | 1 | CPU clock enable |
| xtal_osc_en | output | 1 | High-speed crystal oscillator enable |
| hs_int_osc_en | output | 1 | Internal high-speed oscillator enable |
| resume_pulse | output | 1 | One-cycle strobe on return to active |
| stab_sel | output | 3 | Current wait-length select |
| stab_status | output | 7 | Stabilization progress, thermometer coded |

## Verification
A standby request and a pending interrupt can arrive in the same cycle. The bench drives `irq_pend` high on the same edge as `halt_req`, and again with `stop_req`. In both cases it expects `cpu_clk_en` to stay 1 with no strobe on the next cycle. A halt request and a stop request can also coincide. The bench raises both together, once on each clock source, and judges which standby depth was taken by looking at the oscillator enables.

// File: rtl/sby_pkg.sv
package sby_pkg;

  localparam int SBY_SEL_W = 3;
  localparam int SBY_LVLS  = 7;

  typedef enum logic [1:0] {
    SBY_ACTIVE = 2'd0,
    SBY_HALT   = 2'd1,
    SBY_STOP   = 2'd2,
    SBY_WAKE   = 2'd3
  } sby_state_e;

  // select code -> threshold level; codes 5 and 6 share a level
  function automatic int unsigned sel_to_lvl(input logic [SBY_SEL_W-1:0] code);
    case (code)
      3'd0:    return 0;
      3'd1:    return 1;
      3'd2:    return 2;
      3'd3:    return 3;
      3'd4:    return 4;
      3'd5:    return 5;
      3'd6:    return 5;
      default: return 6;
    endcase
  endfunction

  // exponent offset above the base for each level
  function automatic int unsigned lvl_exp_off(input int unsigned lvl);
    return (lvl == 0) ? 0 : lvl + 1;
  endfunction

endpackage

// File: rtl/sby_sel_reg.sv
module sby_sel_reg
  import sby_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 cpu_active,
  input  logic [SBY_SEL_W-1:0] wr_data,
  output logic [SBY_SEL_W-1:0] sel_q
);

  logic                 load_ok;
  logic [SBY_SEL_W-1:0] sel_d;

  always_comb begin
    load_ok = wr_en & cpu_active;
    sel_d   = load_ok ? wr_data : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '1;
    else        sel_q <= sel_d;
  end

endmodule

// File: rtl/sby_stab_cnt.sv
module sby_stab_cnt
  import sby_pkg::*;
#(
  parameter int EXP_BASE = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 run,
  input  logic                 tick,
  input  logic [SBY_SEL_W-1:0] sel,
  output logic [SBY_LVLS-1:0]  status,
  output logic                 done
);

  localparam int CNT_W = EXP_BASE + 8;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, sel_thr;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    sel_thr = CNT_W'(1) << (EXP_BASE + lvl_exp_off(sel_to_lvl(sel)));
    done    = run & tick & (cnt_inc == sel_thr);
    if (clr)              cnt_d = '0;
    else if (run && tick) cnt_d = cnt_inc;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < SBY_LVLS; g++) begin : g_lvl
    localparam logic [CNT_W-1:0] LVL_THR = CNT_W'(1) << (EXP_BASE + lvl_exp_off(g));
    assign status[g] = (cnt_q >= LVL_THR);
  end

endmodule

// File: rtl/sby_fsm.sv
module sby_fsm
  import sby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic stop_req,
  input  logic clk_on_sub,
  input  logic main_is_xtal,
  input  logic irq_pend,
  input  logic wait_done,
  output logic cnt_clr,
  output logic cnt_run,
  output logic cpu_active,
  output logic osc_on,
  output logic resume_q
);

  sby_state_e st_q, st_d;
  logic       resume_d;

  always_comb begin
    st_d     = st_q;
    resume_d = 1'b0;
    cnt_clr  = 1'b0;
    case (st_q)
      SBY_ACTIVE: begin
        if (!irq_pend) begin
          if (stop_req && !clk_on_sub) begin
            st_d    = SBY_STOP;
            cnt_clr = 1'b1;
          end else if (halt_req) begin
            st_d = SBY_HALT;
          end
        end
      end
      SBY_HALT: begin
        if (irq_pend) begin
          st_d     = SBY_ACTIVE;
          resume_d = 1'b1;
        end
      end
      SBY_STOP: begin
        if (irq_pend) begin
          if (main_is_xtal) begin
            st_d = SBY_WAKE;
          end else begin
            st_d     = SBY_ACTIVE;
            resume_d = 1'b1;
          end
        end
      end
      SBY_WAKE: begin
        if (wait_done) begin
          st_d     = SBY_ACTIVE;
          resume_d = 1'b1;
        end
      end
      default: st_d = SBY_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SBY_ACTIVE;
      resume_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      resume_q <= resume_d;
    end
  end

  always_comb begin
    cpu_active = (st_q == SBY_ACTIVE);
    osc_on     = (st_q != SBY_STOP);
    cnt_run    = (st_q == SBY_WAKE);
  end

endmodule

// File: rtl/sby_ctrl.sv
module sby_ctrl
  import sby_pkg::*;
#(
  parameter int EXP_BASE = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 halt_req,
  input  logic                 stop_req,
  input  logic                 clk_on_sub,
  input  logic                 main_is_xtal,
  input  logic                 irq_pend,
  input  logic                 osc_tick,
  input  logic                 sel_we,
  input  logic [SBY_SEL_W-1:0] sel_wdata,
  output logic                 cpu_clk_en,
  output logic                 xtal_osc_en,
  output logic                 hs_int_osc_en,
  output logic                 resume_pulse,
  output logic [SBY_SEL_W-1:0] stab_sel,
  output logic [SBY_LVLS-1:0]  stab_status
);

  logic cnt_clr, cnt_run, wait_done, cpu_active, osc_on;

  sby_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .stop_req     (stop_req),
    .clk_on_sub   (clk_on_sub),
    .main_is_xtal (main_is_xtal),
    .irq_pend     (irq_pend),
    .wait_done    (wait_done),
    .cnt_clr      (cnt_clr),
    .cnt_run      (cnt_run),
    .cpu_active   (cpu_active),
    .osc_on       (osc_on),
    .resume_q     (resume_pulse)
  );

  sby_stab_cnt #(.EXP_BASE(EXP_BASE)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .run    (cnt_run),
    .tick   (osc_tick),
    .sel    (stab_sel),
    .status (stab_status),
    .done   (wait_done)
  );

  sby_sel_reg u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (sel_we),
    .cpu_active (cpu_active),
    .wr_data    (sel_wdata),
    .sel_q      (stab_sel)
  );

  assign cpu_clk_en    = cpu_active;
  assign xtal_osc_en   = osc_on;
  assign hs_int_osc_en = osc_on;

endmodule

// File: rtl/sby_ctrl_chk.sv
module sby_ctrl_chk #(
  parameter int SEL_W = 3,
  parameter int LVLS  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt_req,
  input logic             stop_req,
  input logic             clk_on_sub,
  input logic             irq_pend,
  input logic             cpu_clk_en,
  input logic             xtal_osc_en,
  input logic             hs_int_osc_en,
  input logic             resume_pulse,
  input logic [SEL_W-1:0] stab_sel,
  input logic [LVLS-1:0]  stab_status
);

  p_halt_keeps_osc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && halt_req && !stop_req && !irq_pend |=> !cpu_clk_en && xtal_osc_en && hs_int_osc_en);

  p_stop_osc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && stop_req && !clk_on_sub && !irq_pend |=> !xtal_osc_en && !hs_int_osc_en && stab_status == '0);

  p_gate_in_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_osc_en |-> !cpu_clk_en && !hs_int_osc_en);

  p_sub_stop_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && stop_req && clk_on_sub && !halt_req && !irq_pend |=> cpu_clk_en && !resume_pulse);

  p_irq_skips_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en && irq_pend |=> cpu_clk_en);

  p_resume_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |=> !resume_pulse);

  p_resume_clk_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pulse |-> cpu_clk_en && xtal_osc_en);

  p_status_thermo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stab_status & (stab_status + LVLS'(1))) == '0);

  p_sel_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |=> $stable(stab_sel));

endmodule

bind sby_ctrl sby_ctrl_chk #(.SEL_W(3), .LVLS(7)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_req      (halt_req),
  .stop_req      (stop_req),
  .clk_on_sub    (clk_on_sub),
  .irq_pend      (irq_pend),
  .cpu_clk_en    (cpu_clk_en),
  .xtal_osc_en   (xtal_osc_en),
  .hs_int_osc_en (hs_int_osc_en),
  .resume_pulse  (resume_pulse),
  .stab_sel      (stab_sel),
  .stab_status   (stab_status)
);

// File: tb/tb_sby_ctrl.sv
module tb_sby_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int B          = 2;

  logic       clk, rst_n;
  logic       halt_req, stop_req, clk_on_sub, main_is_xtal, irq_pend, osc_tick, sel_we;
  logic [2:0] sel_wdata;
  logic       cpu_clk_en, xtal_osc_en, hs_int_osc_en, resume_pulse;
  logic [2:0] stab_sel;
  logic [6:0] stab_status;

  int n_chk  = 0;
  int n_fail = 0;

  sby_ctrl #(.EXP_BASE(B)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .clk_on_sub(clk_on_sub), .main_is_xtal(main_is_xtal), .irq_pend(irq_pend),
    .osc_tick(osc_tick), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .cpu_clk_en(cpu_clk_en), .xtal_osc_en(xtal_osc_en), .hs_int_osc_en(hs_int_osc_en),
    .resume_pulse(resume_pulse), .stab_sel(stab_sel), .stab_status(stab_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {sel code, ticks to wait (R8 with B=2), status after wake (R9)}
  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] ticks;
    logic [6:0]  stat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 16'd4,   7'b0000001},
    '{3'd1, 16'd16,  7'b0000011},
    '{3'd2, 16'd32,  7'b0000111},
    '{3'd3, 16'd64,  7'b0001111},
    '{3'd4, 16'd128, 7'b0011111},
    '{3'd5, 16'd256, 7'b0111111},
    '{3'd6, 16'd256, 7'b0111111},
    '{3'd7, 16'd512, 7'b1111111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_sel(input logic [2:0] v);
    sel_we = 1'b1; sel_wdata = v;
    cyc();
    sel_we = 1'b0;
  endtask

  // count edges from now until resume_pulse is seen
  task automatic wait_resume(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      cyc();
      n++;
      if (resume_pulse) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; halt_req = 0; stop_req = 0; clk_on_sub = 0; main_is_xtal = 1;
    irq_pend = 0; osc_tick = 0; sel_we = 0; sel_wdata = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();

    // reset state (R8, R9)
    chk("R8 reset sel", stab_sel, 3'd7);
    chk("R9 reset status", stab_status, 7'd0);
    chk("R5 reset clk", cpu_clk_en, 1);
    chk("R5 reset strobe", resume_pulse, 0);
    chk("R1 reset osc", {xtal_osc_en, hs_int_osc_en}, 2'b11);

    // table walk: deep standby with crystal, each select code (R7, R8, R9, R2)
    foreach (VECS[i]) begin
      write_sel(VECS[i].sel);
      chk("R10 sel write", stab_sel, VECS[i].sel);
      stop_req = 1'b1; cyc(); stop_req = 1'b0;
      chk("R2 stop gated", {cpu_clk_en, xtal_osc_en, hs_int_osc_en}, 3'b000);
      chk("R2 status cleared", stab_status, 7'd0);
      irq_pend = 1'b1; osc_tick = 1'b1;
      wait_resume(n);
      chk("R7 wake length", n, VECS[i].ticks + 1);
      chk("R7 clk on at resume", cpu_clk_en, 1);
      chk("R9 status at resume", stab_status, VECS[i].stat);
      irq_pend = 1'b0; osc_tick = 1'b0;
      cyc(); cyc();
      chk("R9 status held", stab_status, VECS[i].stat);
    end

    // R7: ticks only counted when osc_tick is high
    write_sel(3'd0);
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    chk("R7 osc back on", {xtal_osc_en, hs_int_osc_en}, 2'b11);
    repeat (10) cyc();
    chk("R7 still gated w/o ticks", cpu_clk_en, 0);
    chk("R9 no progress w/o ticks", stab_status, 7'd0);
    osc_tick = 1'b1;
    wait_resume(n);
    chk("R7 tick gated wake length", n, 4);
    osc_tick = 1'b0;
    cyc();

    // R1 / R5: halt and immediate resume, R10 write ignored in standby
    write_sel(3'd3);
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    chk("R1 halt gated", {cpu_clk_en, xtal_osc_en, hs_int_osc_en}, 3'b011);
    sel_we = 1'b1; sel_wdata = 3'd0; cyc(); sel_we = 1'b0;
    chk("R10 write ignored in halt", stab_sel, 3'd3);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    chk("R5 halt resume clk", cpu_clk_en, 1);
    chk("R5 halt resume strobe", resume_pulse, 1);
    cyc();
    chk("R5 strobe one cycle", resume_pulse, 0);
    chk("R10 sel after halt", stab_sel, 3'd3);

    // R6: deep standby on internal main clock
    main_is_xtal = 1'b0;
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    chk("R6 stop gated", {cpu_clk_en, xtal_osc_en}, 2'b00);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    chk("R6 immediate resume", {cpu_clk_en, resume_pulse, xtal_osc_en, hs_int_osc_en}, 4'b1111);
    cyc();

    // R3: subsystem clock
    clk_on_sub = 1'b1;
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    chk("R3 stop ignored on sub", {cpu_clk_en, resume_pulse, xtal_osc_en}, 3'b101);
    halt_req = 1'b1; cyc(); halt_req = 1'b0;
    chk("R3 halt on sub", {cpu_clk_en, xtal_osc_en}, 2'b01);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    chk("R3 wake from sub halt", cpu_clk_en, 1);

    // R11: simultaneous requests
    halt_req = 1'b1; stop_req = 1'b1; cyc(); halt_req = 1'b0; stop_req = 1'b0;
    chk("R11 sub picks halt", {cpu_clk_en, xtal_osc_en}, 2'b01);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    clk_on_sub = 1'b0;
    halt_req = 1'b1; stop_req = 1'b1; cyc(); halt_req = 1'b0; stop_req = 1'b0;
    chk("R11 main picks stop", {cpu_clk_en, xtal_osc_en}, 2'b00);
    irq_pend = 1'b1; cyc(); irq_pend = 1'b0;
    chk("R11 wake", cpu_clk_en, 1);

    // R4: request and pending interrupt in the same cycle
    irq_pend = 1'b1; halt_req = 1'b1; cyc(); halt_req = 1'b0;
    chk("R4 halt skipped", {cpu_clk_en, resume_pulse}, 2'b10);
    stop_req = 1'b1; cyc(); stop_req = 1'b0;
    chk("R4 stop skipped", {cpu_clk_en, resume_pulse, xtal_osc_en}, 3'b101);
    irq_pend = 1'b0;
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule